// File: doc/BRIEF.md
# Seconds Real-Time Clock Register Block

This block keeps wall-clock time as a 32-bit count of seconds and exposes it on a simple 32-bit register bus. An external one-pulse-per-second strobe advances the count. Software can load a new value at any time and read it back through two read views. A free-running sub-second counter measures the clock cycles since the last strobe. A stored trim value, a control word, an alarm compare value and a scratch word are also held.

Two interrupt groups share one structure. The time-event group has two sticky status bits: one for a seconds step and one for reaching the alarm value. The address-error group has one status bit, set by any access to an unmapped word. Status bits clear when software writes a one to them. The mask registers cannot be written directly. Software changes them only through a pair of strobe registers per group: one unmasks, one masks. Each group drives a level interrupt output.

Bus accesses are handled by a two-state controller. In `BUS_IDLE` a held request is accepted and its effects take place at that clock edge; the controller then moves to `BUS_REPLY` (transition "accept"). `BUS_REPLY` raises the acknowledge for exactly one cycle with any read data and always returns to `BUS_IDLE` (transition "release"). The requester drops its request in the acknowledge cycle.

Top module: `sec_rtc`

## Requirements
- R1: After reset the seconds count and both status registers read 0, the event mask (word 7) reads 0b11, the error mask (word 11) reads 1, the control word (word 14) reads 0x0100_0000, and both interrupt outputs are low.
- R2: A write to word 0 loads the seconds count. Words 0 and 1 both read the live count. Each strobe on `sec_tick` adds one to the count. If a load and a strobe meet in the same cycle, the load wins and no step is counted.
- R3: An accepted request is acknowledged in the following cycle, for one cycle only, and read data is valid with the acknowledge. An access whose byte strobe is not 4'b1111 has no effect and reads zero.
- R4: Event status (word 6) bit 1 is set by every applied seconds step. Bit 0 is set when a step brings the count to the alarm value (word 5). Writing a 1 clears a bit. A hardware set in the same cycle as a clear wins.
- R5: The event mask (word 7) ignores direct writes. A write to word 8 clears the mask bits written as 1. A write to word 9 sets them. Words 8 and 9 read zero.
- R6: `irq_evt` is high exactly when some event status bit is set and its mask bit is clear. `irq_err` follows the same rule for the error group.
- R7: Any access to word 16 or above sets error status (word 10) bit 0, changes no register and reads zero. That bit clears when a 1 is written to it. Its mask (word 11) is cleared through word 12 and set through word 13.
- R8: Control bits in 0x70FF_FFFE ignore writes and read zero; the other bits are writable.
- R9: A write to word 2 stores its low 21 bits as the trim value, readable at word 3. Word 2 reads zero and word 3 ignores writes.
- R10: Word 4 returns the number of cycles since the last strobe. It restarts at 0 on a strobe and holds at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| bus_req | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_idx | input | 5 | Word index of the access |
| bus_strb | input | 4 | Byte strobes; only 4'b1111 is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| irq_evt | output | 1 | Time-event interrupt level |
| irq_err | output | 1 | Address-error interrupt level |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a seconds strobe that sets event status bit 1 and a write-one-to-clear of that same bit. The second pair is a strobe and a load of the seconds count. The bench provokes each pair by raising `sec_tick` in the same cycle as the bus request. It then reads back and expects the status bit to remain set in the first case. In the second case it expects the loaded value exactly, with no step and no status set.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE  = 1'b0,
        BUS_REPLY = 1'b1
    } bus_state_e;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MAP_WORDS = 16;
    localparam int unsigned MAP_BITS  = $clog2(MAP_WORDS);

    localparam logic [MAP_BITS-1:0] W_TIME_LOAD   = 4'd0;
    localparam logic [MAP_BITS-1:0] W_TIME_NOW    = 4'd1;
    localparam logic [MAP_BITS-1:0] W_TRIM_LOAD   = 4'd2;
    localparam logic [MAP_BITS-1:0] W_TRIM_VIEW   = 4'd3;
    localparam logic [MAP_BITS-1:0] W_SUBSEC      = 4'd4;
    localparam logic [MAP_BITS-1:0] W_ALARM       = 4'd5;
    localparam logic [MAP_BITS-1:0] W_EVT_STAT    = 4'd6;
    localparam logic [MAP_BITS-1:0] W_EVT_MASK    = 4'd7;
    localparam logic [MAP_BITS-1:0] W_EVT_UNMASK  = 4'd8;
    localparam logic [MAP_BITS-1:0] W_EVT_MASKSET = 4'd9;
    localparam logic [MAP_BITS-1:0] W_ERR_STAT    = 4'd10;
    localparam logic [MAP_BITS-1:0] W_ERR_MASK    = 4'd11;
    localparam logic [MAP_BITS-1:0] W_ERR_UNMASK  = 4'd12;
    localparam logic [MAP_BITS-1:0] W_ERR_MASKSET = 4'd13;
    localparam logic [MAP_BITS-1:0] W_CTRL        = 4'd14;
    localparam logic [MAP_BITS-1:0] W_SCRATCH     = 4'd15;

    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0100_0000;
    localparam logic [WORD_W-1:0] CTRL_RSVD  = 32'h70FF_FFFE;

endpackage

// File: rtl/sec_rtc_bus.sv
module sec_rtc_bus
    import sec_rtc_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W/8-1:0] strb,
    input  logic [DATA_W-1:0] rd_word,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_en,
    output logic              err_hit
);
    localparam int unsigned STRB_W = DATA_W / 8;

    bus_state_e state_q, state_d;
    logic       fire;
    logic       full_word;
    logic       mapped;
    logic [DATA_W-1:0] rdata_q;

    assign full_word = (strb == {STRB_W{1'b1}});
    assign mapped    = (idx < IDX_W'(MAP_WORDS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (req) begin
                    fire    = 1'b1;
                    state_d = BUS_REPLY;
                end
            end
            BUS_REPLY: begin
                ack     = 1'b1;
                state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    assign wr_en   = fire && we && full_word && mapped;
    assign err_hit = fire && full_word && !mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (fire) begin
            rdata_q <= (!we && full_word && mapped) ? rd_word : '0;
        end
    end

    assign rdata = rdata_q;

    p_ack_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> ack);

endmodule

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned SUB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_val,
    input  logic [SEC_W-1:0] alarm,
    output logic [SEC_W-1:0] seconds,
    output logic [SUB_W-1:0] subsec,
    output logic             step,
    output logic             alarm_hit
);
    localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

    logic [SEC_W-1:0] sec_q;
    logic [SEC_W-1:0] sec_inc;
    logic [SUB_W-1:0] sub_q;

    assign sec_inc   = sec_q + SEC_W'(1);
    assign step      = tick && !load_en;
    assign alarm_hit = step && (sec_inc == alarm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sec_q <= '0;
        else if (load_en) sec_q <= load_val;
        else if (tick)    sec_q <= sec_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sub_q <= '0;
        else if (tick)             sub_q <= '0;
        else if (sub_q != SUB_MAX) sub_q <= sub_q + SUB_W'(1);
    end

    assign seconds = sec_q;
    assign subsec  = sub_q;

    p_step_adds_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (seconds == $past(seconds) + SEC_W'(1)));

    p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (seconds == $past(load_val)));

    p_subsec_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((subsec == SUB_MAX) && !tick) |=> (subsec == SUB_MAX));

endmodule

// File: rtl/sec_rtc_irq_grp.sv
module sec_rtc_irq_grp #(
    parameter int unsigned NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] hw_set,
    input  logic             clr_we,
    input  logic             unmask_we,
    input  logic             maskset_we,
    input  logic [NBITS-1:0] wbits,
    output logic [NBITS-1:0] stat,
    output logic [NBITS-1:0] mask,
    output logic             irq
);
    logic [NBITS-1:0] stat_q;
    logic [NBITS-1:0] mask_q;
    logic [NBITS-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_q <= '1;
        else if (unmask_we)  mask_q <= mask_q & ~wbits;
        else if (maskset_we) mask_q <= mask_q | wbits;
    end

    assign stat = stat_q;
    assign mask = mask_q;
    assign irq  = |(stat_q & ~mask_q);

    p_hw_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((stat & $past(hw_set)) == $past(hw_set)));

    p_mask_only_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_we && !maskset_we) |=> $stable(mask));

    p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((stat & $past(stat)) == $past(stat)));

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned SUB_W  = 16,
    parameter int unsigned TRIM_W = 21
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_tick,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [3:0]  bus_strb,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic [31:0] bus_rdata,
    output logic        irq_evt,
    output logic        irq_err
);
    localparam int unsigned EVT_N = 2;
    localparam int unsigned ERR_N = 1;

    logic [MAP_BITS-1:0] widx;
    logic                wr_en;
    logic                err_hit;
    logic [WORD_W-1:0]   rd_word;

    logic [WORD_W-1:0]   seconds;
    logic [SUB_W-1:0]    subsec;
    logic                step;
    logic                alarm_hit;

    logic [WORD_W-1:0]   alarm_q;
    logic [TRIM_W-1:0]   trim_q;
    logic [WORD_W-1:0]   ctrl_q;
    logic [WORD_W-1:0]   scratch_q;

    logic [EVT_N-1:0]    evt_stat, evt_mask;
    logic [ERR_N-1:0]    err_stat, err_mask;

    logic wr_time, wr_trim, wr_alarm, wr_ctrl, wr_scratch;
    logic wr_evt_clr, wr_evt_un, wr_evt_set;
    logic wr_err_clr, wr_err_un, wr_err_set;

    assign widx = bus_idx[MAP_BITS-1:0];

    sec_rtc_bus #(
        .IDX_W  (IDX_W),
        .DATA_W (WORD_W)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .idx     (bus_idx),
        .strb    (bus_strb),
        .rd_word (rd_word),
        .ack     (bus_ack),
        .rdata   (bus_rdata),
        .wr_en   (wr_en),
        .err_hit (err_hit)
    );

    assign wr_time    = wr_en && (widx == W_TIME_LOAD);
    assign wr_trim    = wr_en && (widx == W_TRIM_LOAD);
    assign wr_alarm   = wr_en && (widx == W_ALARM);
    assign wr_evt_clr = wr_en && (widx == W_EVT_STAT);
    assign wr_evt_un  = wr_en && (widx == W_EVT_UNMASK);
    assign wr_evt_set = wr_en && (widx == W_EVT_MASKSET);
    assign wr_err_clr = wr_en && (widx == W_ERR_STAT);
    assign wr_err_un  = wr_en && (widx == W_ERR_UNMASK);
    assign wr_err_set = wr_en && (widx == W_ERR_MASKSET);
    assign wr_ctrl    = wr_en && (widx == W_CTRL);
    assign wr_scratch = wr_en && (widx == W_SCRATCH);

    sec_rtc_count #(
        .SEC_W (WORD_W),
        .SUB_W (SUB_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load_en   (wr_time),
        .load_val  (bus_wdata),
        .alarm     (alarm_q),
        .seconds   (seconds),
        .subsec    (subsec),
        .step      (step),
        .alarm_hit (alarm_hit)
    );

    sec_rtc_irq_grp #(
        .NBITS (EVT_N)
    ) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set     ({step, alarm_hit}),
        .clr_we     (wr_evt_clr),
        .unmask_we  (wr_evt_un),
        .maskset_we (wr_evt_set),
        .wbits      (bus_wdata[EVT_N-1:0]),
        .stat       (evt_stat),
        .mask       (evt_mask),
        .irq        (irq_evt)
    );

    sec_rtc_irq_grp #(
        .NBITS (ERR_N)
    ) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set     (err_hit),
        .clr_we     (wr_err_clr),
        .unmask_we  (wr_err_un),
        .maskset_we (wr_err_set),
        .wbits      (bus_wdata[ERR_N-1:0]),
        .stat       (err_stat),
        .mask       (err_mask),
        .irq        (irq_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q   <= '0;
            trim_q    <= '0;
            ctrl_q    <= CTRL_RESET;
            scratch_q <= '0;
        end else begin
            if (wr_alarm)   alarm_q   <= bus_wdata;
            if (wr_trim)    trim_q    <= bus_wdata[TRIM_W-1:0];
            if (wr_ctrl)    ctrl_q    <= bus_wdata & ~CTRL_RSVD;
            if (wr_scratch) scratch_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (widx)
            W_TIME_LOAD,
            W_TIME_NOW:    rd_word = seconds;
            W_TRIM_VIEW:   rd_word = WORD_W'(trim_q);
            W_SUBSEC:      rd_word = WORD_W'(subsec);
            W_ALARM:       rd_word = alarm_q;
            W_EVT_STAT:    rd_word = WORD_W'(evt_stat);
            W_EVT_MASK:    rd_word = WORD_W'(evt_mask);
            W_ERR_STAT:    rd_word = WORD_W'(err_stat);
            W_ERR_MASK:    rd_word = WORD_W'(err_mask);
            W_CTRL:        rd_word = ctrl_q;
            W_SCRATCH:     rd_word = scratch_q;
            default:       rd_word = '0;
        endcase
    end

    p_unmapped_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |=> ($stable(scratch_q) && $stable(ctrl_q) && $stable(alarm_q)));

    p_irq_low_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mask == '1) |-> !irq_evt);

endmodule

// File: tb/test_sec_rtc.sv
module test_sec_rtc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_idx = '0;
    logic [3:0]  bus_strb = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        irq_evt;
    logic        irq_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sec_rtc i_sec_rtc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_strb  (bus_strb),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .irq_evt   (irq_evt),
        .irq_err   (irq_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one bus access starting at a negedge; optional tick in the same cycle
    task automatic access(input bit we, input logic [4:0] idx, input logic [31:0] wd,
                          input logic [3:0] strb, input bit with_tick,
                          output logic [31:0] rd, output logic ack_seen);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_idx   = idx;
        bus_wdata = wd;
        bus_strb  = strb;
        sec_tick  = with_tick;
        @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
        ack_seen = bus_ack;
        rd       = bus_rdata;
        bus_req  = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] wd);
        logic [31:0] rd;
        logic a;
        access(1'b1, idx, wd, 4'hF, 1'b0, rd, a);
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] idx, input logic [31:0] exp);
        logic [31:0] rd;
        logic a;
        access(1'b0, idx, 32'h0, 4'hF, 1'b0, rd, a);
        check(tag, rd, exp);
    endtask

    task automatic pulse_tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq_evt", {31'b0, irq_evt}, 32'h0);
        check("R1 irq_err", {31'b0, irq_err}, 32'h0);
        rd_chk("R1 seconds", 5'd1, 32'h0);
        rd_chk("R1 evt stat", 5'd6, 32'h0);
        rd_chk("R1 evt mask", 5'd7, 32'h3);
        rd_chk("R1 err stat", 5'd10, 32'h0);
        rd_chk("R1 err mask", 5'd11, 32'h1);
        rd_chk("R1 ctrl", 5'd14, 32'h0100_0000);
    endtask

    task automatic t_protocol();
        logic [31:0] rd;
        logic a;
        bus_req = 1'b1; bus_we = 1'b0; bus_idx = 5'd14; bus_strb = 4'hF;
        check("R3 no ack in request cycle", {31'b0, bus_ack}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R3 ack after accept", {31'b0, bus_ack}, 32'h1);
        check("R3 data with ack", bus_rdata, 32'h0100_0000);
        bus_req = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R3 ack one cycle", {31'b0, bus_ack}, 32'h0);
        access(1'b1, 5'd14, 32'h0, 4'b0011, 1'b0, rd, a);
        rd_chk("R3 partial write ignored", 5'd14, 32'h0100_0000);
        access(1'b0, 5'd14, 32'h0, 4'b1110, 1'b0, rd, a);
        check("R3 partial read zero", rd, 32'h0);
    endtask

    task automatic t_time();
        logic [31:0] rd;
        logic a;
        wr(5'd0, 32'h0000_1000);
        rd_chk("R2 load via word1", 5'd1, 32'h0000_1000);
        rd_chk("R2 load via word0", 5'd0, 32'h0000_1000);
        pulse_tick();
        pulse_tick();
        rd_chk("R2 two steps", 5'd1, 32'h0000_1002);
        wr(5'd6, 32'h3);
        access(1'b1, 5'd0, 32'h0000_01F4, 4'hF, 1'b1, rd, a);
        rd_chk("R2 load beats tick", 5'd1, 32'h0000_01F4);
        rd_chk("R2 no step status on collision", 5'd6, 32'h0);
        wr(5'd1, 32'hDEAD_BEEF);
        rd_chk("R2 word1 read only", 5'd1, 32'h0000_01F4);
    endtask

    task automatic t_alarm_status();
        logic [31:0] rd;
        logic a;
        wr(5'd5, 32'd100);
        wr(5'd0, 32'd98);
        pulse_tick();
        rd_chk("R4 step sets bit1 only", 5'd6, 32'h2);
        pulse_tick();
        rd_chk("R4 alarm sets bit0", 5'd6, 32'h3);
        wr(5'd6, 32'h1);
        rd_chk("R4 w1c bit0 only", 5'd6, 32'h2);
        access(1'b1, 5'd6, 32'h2, 4'hF, 1'b1, rd, a);
        rd_chk("R4 set wins over clear", 5'd6, 32'h2);
        wr(5'd6, 32'h3);
        rd_chk("R4 cleared", 5'd6, 32'h0);
    endtask

    task automatic t_masks();
        pulse_tick();
        check("R6 masked status no irq", {31'b0, irq_evt}, 32'h0);
        wr(5'd8, 32'h2);
        rd_chk("R5 unmask clears bit1", 5'd7, 32'h1);
        check("R6 unmasked irq high", {31'b0, irq_evt}, 32'h1);
        wr(5'd7, 32'h0);
        rd_chk("R5 direct mask write ignored", 5'd7, 32'h1);
        rd_chk("R5 unmask reads zero", 5'd8, 32'h0);
        rd_chk("R5 maskset reads zero", 5'd9, 32'h0);
        wr(5'd9, 32'h2);
        rd_chk("R5 maskset sets bit1", 5'd7, 32'h3);
        check("R6 remasked irq low", {31'b0, irq_evt}, 32'h0);
        wr(5'd8, 32'h1);
        check("R6 unmasked bit without status", {31'b0, irq_evt}, 32'h0);
        wr(5'd6, 32'h3);
        wr(5'd9, 32'h3);
    endtask

    task automatic t_addr_err();
        logic [31:0] rd;
        logic a;
        wr(5'd15, 32'h0000_1234);
        access(1'b0, 5'd20, 32'h0, 4'hF, 1'b0, rd, a);
        check("R7 unmapped read zero", rd, 32'h0);
        rd_chk("R7 err status set", 5'd10, 32'h1);
        check("R6 err masked", {31'b0, irq_err}, 32'h0);
        wr(5'd10, 32'h1);
        rd_chk("R7 err w1c", 5'd10, 32'h0);
        wr(5'd31, 32'hFFFF_FFFF);
        rd_chk("R7 unmapped write no effect", 5'd15, 32'h0000_1234);
        rd_chk("R7 unmapped write sets status", 5'd10, 32'h1);
        wr(5'd12, 32'h1);
        rd_chk("R7 err unmask", 5'd11, 32'h0);
        check("R6 err irq high", {31'b0, irq_err}, 32'h1);
        wr(5'd10, 32'h1);
        check("R6 err irq low after clear", {31'b0, irq_err}, 32'h0);
        wr(5'd13, 32'h1);
        rd_chk("R7 err maskset", 5'd11, 32'h1);
    endtask

    task automatic t_ctrl_trim();
        wr(5'd14, 32'hFFFF_FFFF);
        rd_chk("R8 reserved bits zero", 5'd14, 32'h8F00_0001);
        wr(5'd14, 32'h0);
        rd_chk("R8 writable cleared", 5'd14, 32'h0);
        wr(5'd2, 32'hFFFF_FFFF);
        rd_chk("R9 trim 21 bits", 5'd3, 32'h001F_FFFF);
        rd_chk("R9 trim load reads zero", 5'd2, 32'h0);
        wr(5'd3, 32'h0);
        rd_chk("R9 trim view read only", 5'd3, 32'h001F_FFFF);
    endtask

    task automatic t_subsec();
        pulse_tick();
        rd_chk("R10 restart after tick", 5'd4, 32'h0);
        pulse_tick();
        repeat (10) @(negedge clk);
        rd_chk("R10 counts cycles", 5'd4, 32'd10);
        repeat (66000) @(negedge clk);
        rd_chk("R10 saturates", 5'd4, 32'h0000_FFFF);
        wr(5'd4, 32'h0);
        rd_chk("R10 read only", 5'd4, 32'h0000_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protocol();
        t_time();
        t_alarm_status();
        t_masks();
        t_addr_err();
        t_ctrl_trim();
        t_subsec();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule